// File: doc/BRIEF.md
# Serial Conversion Result Formatter

This block sends a 10-bit conversion result out on a serial data line, one bit for each serial bit strobe. On the same strobes it takes in an 8-bit configuration word. The converter model delivers its count in offset binary, where zero is the bottom of the range. A mode input chooses how that count is reported. In unipolar mode the count passes through unchanged as straight binary. In bipolar mode it is reported as two's complement.

Chip select is active low and is assumed to be already filtered. A transfer opens on the first clock after chip select goes low, and the result is captured at that moment. The configuration word carries two settings:

- The bit order of the *next* transfer's output word.
- The length of the *current* transfer's output word.

The length bits arrive last. For that reason the first eight output bits are always sent, and the chosen length only cuts or pads the tail of the word. A tri-state enable tells the pad when the data line is driven.

Top module: `fmt_serial_top`

## Requirements
- R1: While chip select is high, and from reset, the output enable is low and the data output is 0. Raising chip select returns the bit position to the start, so the next transfer begins again at bit 0.
- R2: With the bipolar input low, the reported code equals the converter count. Count 0 gives 0000000000 and count 1023 gives 1111111111.
- R3: With the bipolar input high, the reported code is two's complement: the count with its top bit inverted. Count 512 gives 0000000000 and count 513 gives 0000000001. Count 511 gives 1111111111 and count 0 gives 1000000000.
- R4: Configuration bits are numbered 0 to 7 in the order they are received. Bit 5 selects the output order: 1 for most significant bit first, 0 for least significant bit first. In LSB-first order, output bit k is code bit k.
- R5: The order bit of a complete configuration word sets the order of the following transfer only. The transfer in which it arrives keeps the order already in effect. After reset the order is MSB first.
- R6: Received bits 6 and 7 form the length select, with bit 6 as the high bit. The values 00, 01, 10 and 11 give 8, 10, 12 and 16 output bits, and the setting applies to the transfer in which it arrives.
- R7: For 12- and 16-bit lengths, every output bit after the ten code bits is 0, in either order.
- R8: For an 8-bit length, only the first eight bits of the chosen order are sent. The output enable falls after the eighth bit.
- R9: Once the selected number of bits has been sent, the output enable stays low until chip select rises. Strobes that arrive while chip select is high have no effect on the next transfer.
- R10: A transfer ended before all 8 configuration bits arrive leaves the pending order unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Filtered chip select, active low |
| bit_tick | input | 1 | One-cycle strobe per serial bit |
| din | input | 1 | Configuration data, sampled on bit_tick |
| raw_code | input | 10 | Converter count, offset binary |
| bipolar | input | 1 | 1 selects two's complement reporting |
| dout | output | 1 | Serial data out, 0 when not enabled |
| dout_oe | output | 1 | Tri-state enable for dout |

## Verification
A wrong bit counter shows at the ports within one strobe. The data line then presents a neighbouring code bit, and the enable falls one bit early or late. A stale captured code shows on the very first bit of a transfer. A pending order that was updated at the wrong time, or from an aborted word, stays hidden for a whole transfer. It only appears as a reversed bit order in the next transfer. The checks therefore run every pattern as pairs of transfers.

// File: rtl/fmt_pkg.sv
package fmt_pkg;
    parameter int RES_W   = 10;
    parameter int CFG_W   = 8;
    parameter int ORD_POS = 5;
    parameter int MAX_LEN = 16;
    localparam int CNT_W  = $clog2(MAX_LEN + 1);

    typedef enum logic [1:0] {
        LEN_8  = 2'b00,
        LEN_10 = 2'b01,
        LEN_12 = 2'b10,
        LEN_16 = 2'b11
    } len_e;

    typedef struct packed {
        logic             act;
        logic [CNT_W-1:0] cnt;
        logic [CFG_W-1:0] cfg;
        logic [RES_W-1:0] word;
        logic             ord_cur;
        logic             ord_pend;
    } fmt_state_t;
endpackage

// File: rtl/fmt_code_conv.sv
module fmt_code_conv #(
    parameter int W = 10
) (
    input  logic [W-1:0] raw,
    input  logic         bipolar,
    output logic [W-1:0] code
);
    always_comb begin
        code = raw;
        if (bipolar) code[W-1] = ~raw[W-1];
    end
endmodule

// File: rtl/fmt_len_dec.sv
module fmt_len_dec
    import fmt_pkg::*;
(
    input  logic [1:0]       sel,
    input  logic             known,
    output logic [CNT_W-1:0] len
);
    always_comb begin
        unique case (len_e'(sel))
            LEN_8:   len = CNT_W'(8);
            LEN_10:  len = CNT_W'(10);
            LEN_12:  len = CNT_W'(12);
            default: len = CNT_W'(16);
        endcase
        if (!known) len = CNT_W'(MAX_LEN);
    end
endmodule

// File: rtl/fmt_bit_pick.sv
module fmt_bit_pick #(
    parameter int W   = 10,
    parameter int IDX_W = 5
) (
    input  logic [W-1:0]     word,
    input  logic [IDX_W-1:0] idx,
    input  logic             msb_first,
    output logic             bit_o
);
    logic [W-1:0] fwd;

    genvar g;
    generate
        for (g = 0; g < W; g++) begin : g_rev
            assign fwd[g] = msb_first ? word[W-1-g] : word[g];
        end
    endgenerate

    always_comb begin
        bit_o = 1'b0;
        for (int i = 0; i < W; i++) begin
            if (idx == IDX_W'(i)) bit_o = fwd[i];
        end
    end
endmodule

// File: rtl/fmt_serial_top.sv
module fmt_serial_top
    import fmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             bit_tick,
    input  logic             din,
    input  logic [RES_W-1:0] raw_code,
    input  logic             bipolar,
    output logic             dout,
    output logic             dout_oe
);
    localparam int ORD_SLOT = CFG_W - 1 - ORD_POS;

    fmt_state_t st_q, st_d;

    logic [RES_W-1:0] code;
    logic [CFG_W-1:0] cfg_nxt;
    logic [CNT_W-1:0] len_cur;
    logic             cfg_known;
    logic             bit_val;

    fmt_code_conv #(.W(RES_W)) u_conv (
        .raw     (raw_code),
        .bipolar (bipolar),
        .code    (code)
    );

    assign cfg_known = (st_q.cnt >= CNT_W'(CFG_W));

    fmt_len_dec u_len (
        .sel   (st_q.cfg[1:0]),
        .known (cfg_known),
        .len   (len_cur)
    );

    fmt_bit_pick #(.W(RES_W), .IDX_W(CNT_W)) u_pick (
        .word      (st_q.word),
        .idx       (st_q.cnt),
        .msb_first (st_q.ord_cur),
        .bit_o     (bit_val)
    );

    always_comb begin
        st_d    = st_q;
        cfg_nxt = {st_q.cfg[CFG_W-2:0], din};
        if (cs_n) begin
            st_d.act = 1'b0;
            st_d.cnt = '0;
        end else if (!st_q.act) begin
            st_d.act     = 1'b1;
            st_d.cnt     = '0;
            st_d.word    = code;
            st_d.ord_cur = st_q.ord_pend;
        end else if (bit_tick) begin
            if (st_q.cnt < CNT_W'(MAX_LEN)) st_d.cnt = st_q.cnt + CNT_W'(1);
            if (st_q.cnt < CNT_W'(CFG_W))   st_d.cfg = cfg_nxt;
            if (st_q.cnt == CNT_W'(CFG_W - 1)) st_d.ord_pend = cfg_nxt[ORD_SLOT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.act      <= 1'b0;
            st_q.cnt      <= '0;
            st_q.cfg      <= '0;
            st_q.word     <= '0;
            st_q.ord_cur  <= 1'b1;
            st_q.ord_pend <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout_oe = st_q.act && (st_q.cnt < len_cur);
    assign dout    = dout_oe && bit_val;
endmodule

// File: rtl/fmt_serial_chk.sv
module fmt_serial_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic bit_tick,
    input logic din,
    input logic dout,
    input logic dout_oe
);
    logic       c_act_q;
    logic [4:0] c_idx_q;
    logic       c_w1_q, c_w0_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_act_q <= 1'b0;
            c_idx_q <= '0;
            c_w1_q  <= 1'b0;
            c_w0_q  <= 1'b0;
        end else if (cs_n) begin
            c_act_q <= 1'b0;
            c_idx_q <= '0;
        end else begin
            c_act_q <= 1'b1;
            if (c_act_q && bit_tick) begin
                if (c_idx_q < 5'd16) c_idx_q <= c_idx_q + 5'd1;
                if (c_idx_q == 5'd6) c_w1_q <= din;
                if (c_idx_q == 5'd7) c_w0_q <= din;
            end
            if (!c_act_q) c_idx_q <= '0;
        end
    end

    AST_IDLE_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !dout_oe); // R1

    AST_HIZ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_oe |-> !dout); // R1

    AST_FILL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_oe && c_idx_q >= 5'd10) |-> !dout); // R7

    AST_SHORT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (c_act_q && c_idx_q >= 5'd8 && !c_w1_q && !c_w0_q) |-> !dout_oe); // R8

    AST_MAX_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (c_act_q && c_idx_q >= 5'd16) |-> !dout_oe); // R9
endmodule

bind fmt_serial_top fmt_serial_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .bit_tick (bit_tick),
    .din      (din),
    .dout     (dout),
    .dout_oe  (dout_oe)
);

// File: tb/fmt_serial_top_test.sv
module fmt_serial_top_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       bit_tick = 1'b0;
    logic       din = 1'b0;
    logic [9:0] raw_code = '0;
    logic       bipolar = 1'b0;
    logic       dout, dout_oe;

    int errors = 0;
    int checks = 0;
    logic pend_ord = 1'b1;   // bench model of the pending order

    always #5 clk = ~clk;

    fmt_serial_top uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .bit_tick(bit_tick), .din(din),
        .raw_code(raw_code), .bipolar(bipolar), .dout(dout), .dout_oe(dout_oe)
    );

    task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got oe/dout=%b expected %b", req, act, exp);
        end
    endtask

    function automatic int len_of(input logic [1:0] sel);
        case (sel)
            2'b00: return 8;
            2'b01: return 10;
            2'b10: return 12;
            default: return 16;
        endcase
    endfunction

    // One transfer; nsend strobes are sent (16 = full), bits checked while cs_n low.
    task automatic xfer(input string req, input logic [9:0] raw, input logic bip,
                        input logic ord, input logic [1:0] lsel, input logic fill,
                        input int nsend);
        logic [9:0] code;
        logic [7:0] cfg;
        logic       cur;
        int         L;
        logic       eb;
        raw_code = raw;
        bipolar  = bip;
        code = bip ? (raw ^ 10'h200) : raw;   // R3: top bit inverted
        cur  = pend_ord;
        for (int i = 0; i < 8; i++) cfg[i] = fill ^ i[0];
        cfg[5] = ord;
        cfg[6] = lsel[1];
        cfg[7] = lsel[0];
        L = len_of(lsel);
        @(negedge clk) cs_n = 1'b0;
        @(negedge clk);
        for (int k = 0; k < nsend; k++) begin
            if (k >= 8 && k >= L) eb = 1'b0;
            else if (k < 10) eb = cur ? code[9-k] : code[k];
            else eb = 1'b0;
            check(req, {dout_oe, dout}, {(k < 8 || k < L) ? 1'b1 : 1'b0, eb});
            bit_tick = 1'b1;
            din = (k < 8) ? cfg[k] : 1'b0;
            @(negedge clk) bit_tick = 1'b0;
            @(negedge clk);
        end
        if (nsend == 16) check({req, " R9 after word"}, {dout_oe, dout}, 2'b00);
        if (nsend >= 8) pend_ord = ord;   // R5 / R10
        cs_n = 1'b1;
        @(negedge clk);
        check({req, " R1 cs high"}, {dout_oe, dout}, 2'b00);
    endtask

    task automatic t_reset;
        #1 check("R1 reset", {dout_oe, dout}, 2'b00);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk) check("R1 idle", {dout_oe, dout}, 2'b00);
    endtask

    task automatic t_unipolar;
        xfer("R2 R5 default MSB", 10'h3FF, 1'b0, 1'b1, 2'b01, 1'b0, 16);
        xfer("R2 zero",           10'h000, 1'b0, 1'b1, 2'b01, 1'b1, 16);
        xfer("R2 pattern",        10'h2C5, 1'b0, 1'b1, 2'b11, 1'b0, 16);
    endtask

    task automatic t_bipolar;
        xfer("R3 zero",     10'h200, 1'b1, 1'b1, 2'b01, 1'b0, 16);
        xfer("R3 plus one", 10'h201, 1'b1, 1'b1, 2'b01, 1'b1, 16);
        xfer("R3 minus one",10'h1FF, 1'b1, 1'b1, 2'b01, 1'b0, 16);
        xfer("R3 most neg", 10'h000, 1'b1, 1'b1, 2'b01, 1'b1, 16);
    endtask

    task automatic t_order;
        xfer("R5 order set LSB, still MSB", 10'h0B3, 1'b0, 1'b0, 2'b01, 1'b0, 16);
        xfer("R4 LSB first",                10'h0B3, 1'b0, 1'b0, 2'b10, 1'b1, 16);
        xfer("R7 LSB fill 16",              10'h3C1, 1'b0, 1'b1, 2'b11, 1'b0, 16);
        xfer("R4 back to MSB",              10'h3C1, 1'b0, 1'b1, 2'b01, 1'b0, 16);
    endtask

    task automatic t_lengths;
        xfer("R8 len 8 MSB",  10'h2AB, 1'b0, 1'b0, 2'b00, 1'b1, 16);
        xfer("R8 len 8 LSB",  10'h2AB, 1'b0, 1'b1, 2'b00, 1'b0, 16);
        xfer("R6 R7 len 12",  10'h3FF, 1'b0, 1'b1, 2'b10, 1'b0, 16);
        xfer("R6 R7 len 16",  10'h3FF, 1'b1, 1'b1, 2'b11, 1'b1, 16);
    endtask

    task automatic t_abort;
        xfer("R10 aborted word", 10'h155, 1'b0, 1'b0, 2'b01, 1'b0, 4);
        xfer("R10 order kept",   10'h155, 1'b0, 1'b1, 2'b01, 1'b0, 16);
    endtask

    task automatic t_idle_ticks;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk) begin bit_tick = 1'b1; din = 1'b1; end
            @(negedge clk) bit_tick = 1'b0;
            check("R9 idle strobe", {dout_oe, dout}, 2'b00);
        end
        xfer("R9 R1 restart at bit 0", 10'h301, 1'b0, 1'b1, 2'b01, 1'b0, 16);
    endtask

    initial begin
        t_reset();
        t_unipolar();
        t_bipolar();
        t_order();
        t_lengths();
        t_abort();
        t_idle_ticks();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1ms;
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule